// File: doc/BRIEF.md
# Credit-Gated Message Ring Station

This block is the processor-facing end point of an on-chip message ring. Software stages a message of one to four 64-bit words in four transmit slots. It then issues a send command that packs the destination station, an 8-bit code and the word count minus one into one word. A send leaves the station only if the station holds a credit for that destination. Each station ID has its own credit counter. A send that has no credit is not stalled: it is refused, and a sticky status bit records the refusal.

Incoming messages that address this core are sorted into eight receive buckets by the low three bits of the destination ID. Each bucket is a small FIFO, and its capacity is limited by a size register that software can write. Software asks for a message from one bucket. A load-pending flag stays up until that bucket can supply a message. The message's size, code and source station then appear in the status word, and its words appear in the receive slots. Each pop sends a credit back toward the sender. In the bench, the ring output and the credit output are wired straight back to the inputs.

Top module: `msg_station`

## Requirements
- R1: A send with credit puts one message on the ring one cycle after the command. Its destination is send_word[6:0], its code is send_word[15:8], its size-minus-one is send_word[17:16], its source is CORE_ID*8 and its data is the four transmit slots.
- R2: A send whose destination counter is zero emits nothing, leaves the counter unchanged and sets status[2]. status[2] stays set until a later send succeeds.
- R3: A successful send lowers the credit counter of its destination by exactly one.
- R4: status[1] (send in flight) is 1 in the cycle the ring output carries the message and 0 otherwise.
- R5: A receive command sets status[3]. status[3] stays 1 for as long as the named bucket is empty.
- R6: When the bucket delivers, status[3] clears and status[7:6], [15:8] and [22:16] show size-minus-one, code and source. The rx_word output for rx_slot 0..3 shows the data words.
- R7: A pop raises cr_out_vld for one cycle with cr_out_stn = CORE_ID*8 + bucket. A credit return increments that station's counter at the next edge, and the counter saturates at 255.
- R8: A ring message is accepted only when dst[6:3] equals CORE_ID. It goes to bucket dst[2:0], and a bucket hands out its messages in arrival order.
- R9: A bucket holds at most min(size register, DEPTH) messages. An arrival at a full bucket is dropped and sets status[4]. A later accepted receive command clears status[4].
- R10: A receive command issued while status[3] is 1 is ignored and sets status[5]. The next accepted receive command clears status[5].
- R11: After reset, all credit counters, all bucket sizes and the whole status word are zero, and no message is on the ring.
- R12: Configuration: with cfg_sel=0, cfg_idx selects a credit counter. With cfg_sel=1, cfg_idx[2:0] selects a bucket size. cfg_rdata shows the selected value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txw_en | input | 1 | Write one transmit slot |
| txw_slot | input | 2 | Transmit slot index |
| txw_data | input | 64 | Transmit slot data |
| send_vld | input | 1 | Issue send command |
| send_word | input | 18 | Send command: dst[6:0], code[15:8], size-1[17:16] |
| recv_vld | input | 1 | Issue receive command |
| recv_bkt | input | 3 | Bucket to receive from |
| cfg_wr | input | 1 | Configuration write |
| cfg_sel | input | 1 | 0 credit counter, 1 bucket size |
| cfg_idx | input | 7 | Configuration index |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration read value |
| status | output | 32 | Status word |
| rx_slot | input | 2 | Receive slot select |
| rx_word | output | 64 | Selected receive slot data |
| ring_out_vld | output | 1 | Outgoing message valid |
| ring_out_dst | output | 7 | Outgoing destination station |
| ring_out_src | output | 7 | Outgoing source station |
| ring_out_code | output | 8 | Outgoing code |
| ring_out_szm1 | output | 2 | Outgoing size minus one |
| ring_out_data | output | 256 | Outgoing four data words |
| ring_in_vld | input | 1 | Incoming message valid |
| ring_in_dst | input | 7 | Incoming destination station |
| ring_in_src | input | 7 | Incoming source station |
| ring_in_code | input | 8 | Incoming code |
| ring_in_szm1 | input | 2 | Incoming size minus one |
| ring_in_data | input | 256 | Incoming four data words |
| cr_out_vld | output | 1 | Credit return valid |
| cr_out_stn | output | 7 | Station whose bucket popped |
| cr_in_vld | input | 1 | Incoming credit return |
| cr_in_stn | input | 7 | Station credited |

## Verification
The send and receive path is tried with three kinds of traffic. Sends to stations with zero and non-zero credit tell a refused send from a transmitted one. Sends to this core and to other cores tell accepted deliveries from ignored ones. Random interleavings of sends, pops and credit rewrites against buckets of sizes 1 to 4 tell correct FIFO ordering and capacity limits from dropped or reordered messages. Receives on an empty bucket, a second receive while one is pending, and a pop into a counter already at 255 show that pending, busy and saturation are handled apart from the normal path.

// File: rtl/msgst_pkg.sv
package msgst_pkg;
    localparam int STN_W  = 7;
    localparam int CODE_W = 8;
    localparam int SZ_W   = 2;
    localparam int WORD_W = 64;
    localparam int NSLOT  = 4;
    localparam int NBKT   = 8;
    localparam int BKT_W  = $clog2(NBKT);
    localparam int NSTN   = 1 << STN_W;

    typedef struct packed {
        logic [STN_W-1:0]             dst;
        logic [STN_W-1:0]             src;
        logic [CODE_W-1:0]            code;
        logic [SZ_W-1:0]              szm1;
        logic [NSLOT-1:0][WORD_W-1:0] data;
    } msg_t;
endpackage

// File: rtl/msgst_credits.sv
module msgst_credits
    import msgst_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [STN_W-1:0] wr_idx,
    input  logic [CW-1:0]    wr_val,
    input  logic             dec_en,
    input  logic [STN_W-1:0] dec_idx,
    input  logic             inc_en,
    input  logic [STN_W-1:0] inc_idx,
    input  logic [STN_W-1:0] rd_a_idx,
    output logic [CW-1:0]    rd_a,
    input  logic [STN_W-1:0] rd_b_idx,
    output logic [CW-1:0]    rd_b
);
    typedef struct packed {
        logic [NSTN-1:0][CW-1:0] cnt;
    } cred_st_t;

    cred_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NSTN; i++) begin
            if (wr_en && wr_idx == STN_W'(i)) begin
                s_d.cnt[i] = wr_val;
            end else begin
                if (inc_en && inc_idx == STN_W'(i) && s_q.cnt[i] != '1)
                    s_d.cnt[i] = s_d.cnt[i] + CW'(1);
                if (dec_en && dec_idx == STN_W'(i) && s_q.cnt[i] != '0)
                    s_d.cnt[i] = s_d.cnt[i] - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_a = s_q.cnt[rd_a_idx];
    assign rd_b = s_q.cnt[rd_b_idx];

    // R2: a decrement is only ever requested for a counter holding credit
    a_r2_dec_has_credit: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> s_q.cnt[dec_idx] != '0);

    // R3: an undisturbed decrement lowers the counter by one
    a_r3_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !inc_en && !wr_en) |=>
            s_q.cnt[$past(dec_idx)] == $past(s_q.cnt[dec_idx]) - CW'(1));

    // R7: counters never wrap from all ones to zero
    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !dec_en && !wr_en && s_q.cnt[inc_idx] == '1) |=>
            s_q.cnt[$past(inc_idx)] == '1);
endmodule

// File: rtl/msgst_bucket.sv
module msgst_bucket
    import msgst_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  msg_t             push_msg,
    input  logic             pop,
    input  logic [LIM_W-1:0] limit,
    output msg_t             head,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0] [$bits(msg_t)-1:0] mem;
        logic [PW-1:0]                       wp;
        logic [PW-1:0]                       rp;
        logic [CW-1:0]                       cnt;
    } bkt_st_t;

    bkt_st_t s_d, s_q;
    logic    push_ok, pop_ok;

    assign empty   = (s_q.cnt == '0);
    assign full    = (int'(s_q.cnt) >= int'(limit)) || (int'(s_q.cnt) >= DEPTH);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = msg_t'(s_q.mem[s_q.rp]);

    always_comb begin
        s_d = s_q;
        if (push_ok) begin
            s_d.mem[s_q.wp] = push_msg;
            s_d.wp = (s_q.wp == PW'(DEPTH - 1)) ? '0 : s_q.wp + PW'(1);
        end
        if (pop_ok)
            s_d.rp = (s_q.rp == PW'(DEPTH - 1)) ? '0 : s_q.rp + PW'(1);
        s_d.cnt = s_q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9: occupancy never exceeds the physical depth
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.cnt) <= DEPTH);

    // R9: an arrival at a full bucket leaves its occupancy alone
    a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> s_q.cnt == $past(s_q.cnt));
endmodule

// File: rtl/msg_station.sv
module msg_station
    import msgst_pkg::*;
#(
    parameter int CORE_ID   = 2,
    parameter int BKT_DEPTH = 4,
    parameter int CFG_W     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    txw_en,
    input  logic [1:0]              txw_slot,
    input  logic [WORD_W-1:0]       txw_data,
    input  logic                    send_vld,
    input  logic [SZ_W+15:0]        send_word,
    input  logic                    recv_vld,
    input  logic [BKT_W-1:0]        recv_bkt,
    input  logic                    cfg_wr,
    input  logic                    cfg_sel,
    input  logic [STN_W-1:0]        cfg_idx,
    input  logic [CFG_W-1:0]        cfg_wdata,
    output logic [CFG_W-1:0]        cfg_rdata,
    output logic [31:0]             status,
    input  logic [1:0]              rx_slot,
    output logic [WORD_W-1:0]       rx_word,
    output logic                    ring_out_vld,
    output logic [STN_W-1:0]        ring_out_dst,
    output logic [STN_W-1:0]        ring_out_src,
    output logic [CODE_W-1:0]       ring_out_code,
    output logic [SZ_W-1:0]         ring_out_szm1,
    output logic [NSLOT*WORD_W-1:0] ring_out_data,
    input  logic                    ring_in_vld,
    input  logic [STN_W-1:0]        ring_in_dst,
    input  logic [STN_W-1:0]        ring_in_src,
    input  logic [CODE_W-1:0]       ring_in_code,
    input  logic [SZ_W-1:0]         ring_in_szm1,
    input  logic [NSLOT*WORD_W-1:0] ring_in_data,
    output logic                    cr_out_vld,
    output logic [STN_W-1:0]        cr_out_stn,
    input  logic                    cr_in_vld,
    input  logic [STN_W-1:0]        cr_in_stn
);
    localparam int BASE_ID = CORE_ID * NBKT;
    localparam int CORE_W  = STN_W - BKT_W;

    typedef struct packed {
        logic                         fail_cred;
        logic                         load_pend;
        logic                         err_drop;
        logic                         err_busy;
        logic [SZ_W-1:0]              rx_szm1;
        logic [CODE_W-1:0]            rx_code;
        logic [STN_W-1:0]             rx_src;
        logic [BKT_W-1:0]             pend_bkt;
        logic [NSLOT-1:0][WORD_W-1:0] tx_buf;
        logic [NSLOT-1:0][WORD_W-1:0] rx_buf;
        logic                         ro_vld;
        msg_t                         ro;
        logic                         cr_vld;
        logic [STN_W-1:0]             cr_stn;
        logic [NBKT-1:0][CFG_W-1:0]   bsize;
    } stn_st_t;

    stn_st_t s_d, s_q;

    logic [CFG_W-1:0]        cred_a, cred_b;
    logic                    dec_en;
    logic [NBKT-1:0]         bkt_empty, bkt_full, bkt_push, bkt_pop;
    msg_t                    bkt_head [NBKT];
    msg_t                    in_msg;
    logic                    in_hit;
    logic [BKT_W-1:0]        in_bkt;
    logic                    pop_ok;
    logic [NBKT-1:0][STN_W-1:0] hd_dst_unused;
    logic                    cmd_bit_unused;

    assign cmd_bit_unused = send_word[7];

    assign in_msg = '{dst: ring_in_dst, src: ring_in_src, code: ring_in_code,
                      szm1: ring_in_szm1, data: ring_in_data};
    assign in_hit = ring_in_vld && (ring_in_dst[STN_W-1:BKT_W] == CORE_W'(CORE_ID));
    assign in_bkt = ring_in_dst[BKT_W-1:0];
    assign pop_ok = s_q.load_pend && !bkt_empty[s_q.pend_bkt];

    msgst_credits #(.CW(CFG_W)) u_cred (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr && !cfg_sel),
        .wr_idx   (cfg_idx),
        .wr_val   (cfg_wdata),
        .dec_en   (dec_en),
        .dec_idx  (send_word[STN_W-1:0]),
        .inc_en   (cr_in_vld),
        .inc_idx  (cr_in_stn),
        .rd_a_idx (send_word[STN_W-1:0]),
        .rd_a     (cred_a),
        .rd_b_idx (cfg_idx),
        .rd_b     (cred_b)
    );

    for (genvar b = 0; b < NBKT; b++) begin : g_bkt
        assign bkt_push[b] = in_hit && (in_bkt == BKT_W'(b));
        assign bkt_pop[b]  = pop_ok && (s_q.pend_bkt == BKT_W'(b));
        assign hd_dst_unused[b] = bkt_head[b].dst;
        msgst_bucket #(.DEPTH(BKT_DEPTH), .LIM_W(CFG_W)) u_bkt (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (bkt_push[b]),
            .push_msg (in_msg),
            .pop      (bkt_pop[b]),
            .limit    (s_q.bsize[b]),
            .head     (bkt_head[b]),
            .empty    (bkt_empty[b]),
            .full     (bkt_full[b])
        );
    end

    always_comb begin
        s_d    = s_q;
        dec_en = 1'b0;
        s_d.ro_vld = 1'b0;
        s_d.cr_vld = 1'b0;

        if (txw_en) s_d.tx_buf[txw_slot] = txw_data;

        if (send_vld) begin
            if (cred_a != '0) begin
                s_d.ro_vld    = 1'b1;
                s_d.ro.dst    = send_word[STN_W-1:0];
                s_d.ro.src    = STN_W'(BASE_ID);
                s_d.ro.code   = send_word[15:8];
                s_d.ro.szm1   = send_word[SZ_W+15:16];
                s_d.ro.data   = s_q.tx_buf;
                s_d.fail_cred = 1'b0;
                dec_en        = 1'b1;
            end else begin
                s_d.fail_cred = 1'b1;
            end
        end

        if (recv_vld) begin
            if (s_q.load_pend) begin
                s_d.err_busy = 1'b1;
            end else begin
                s_d.load_pend = 1'b1;
                s_d.pend_bkt  = recv_bkt;
                s_d.err_drop  = 1'b0;
                s_d.err_busy  = 1'b0;
            end
        end

        if (pop_ok) begin
            s_d.load_pend = 1'b0;
            s_d.rx_szm1   = bkt_head[s_q.pend_bkt].szm1;
            s_d.rx_code   = bkt_head[s_q.pend_bkt].code;
            s_d.rx_src    = bkt_head[s_q.pend_bkt].src;
            s_d.rx_buf    = bkt_head[s_q.pend_bkt].data;
            s_d.cr_vld    = 1'b1;
            s_d.cr_stn    = STN_W'(BASE_ID) + STN_W'(s_q.pend_bkt);
        end

        if (in_hit && bkt_full[in_bkt]) s_d.err_drop = 1'b1;

        if (cfg_wr && cfg_sel) s_d.bsize[cfg_idx[BKT_W-1:0]] = cfg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_rdata     = cfg_sel ? s_q.bsize[cfg_idx[BKT_W-1:0]] : cred_b;
    assign status        = {9'b0, s_q.rx_src, s_q.rx_code, s_q.rx_szm1,
                            s_q.err_busy, s_q.err_drop, s_q.load_pend,
                            s_q.fail_cred, s_q.ro_vld, 1'b0};
    assign rx_word       = s_q.rx_buf[rx_slot];
    assign ring_out_vld  = s_q.ro_vld;
    assign ring_out_dst  = s_q.ro.dst;
    assign ring_out_src  = s_q.ro.src;
    assign ring_out_code = s_q.ro.code;
    assign ring_out_szm1 = s_q.ro.szm1;
    assign ring_out_data = s_q.ro.data;
    assign cr_out_vld    = s_q.cr_vld;
    assign cr_out_stn    = s_q.cr_stn;

    // R1: a send backed by credit appears on the ring next cycle with its destination
    a_r1_send_emits: assert property (@(posedge clk) disable iff (!rst_n)
        (send_vld && cred_a != '0) |=>
            ring_out_vld && ring_out_dst == $past(send_word[STN_W-1:0]));

    // R2: a send without credit emits nothing and flags the failure
    a_r2_no_credit: assert property (@(posedge clk) disable iff (!rst_n)
        (send_vld && cred_a == '0) |=> !ring_out_vld && status[2]);

    // R5: a pending receive on an empty bucket stays pending
    a_r5_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.load_pend && bkt_empty[s_q.pend_bkt]) |=> status[3]);

    // R7: completion of a receive is accompanied by a credit return
    a_r7_credit_ret: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[3]) |-> cr_out_vld);

    // R10: a receive while one is pending marks the busy error
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && recv_vld) |=> status[5]);
endmodule

// File: tb/msg_station_test.sv
`timescale 1ns/1ps
module msg_station_test;
    localparam int CORE  = 2;
    localparam int DEPTH = 4;

    typedef struct packed {
        logic [6:0]       src;
        logic [7:0]       code;
        logic [1:0]       szm1;
        logic [3:0][63:0] d;
    } bmsg_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic txw_en = 0; logic [1:0] txw_slot = 0; logic [63:0] txw_data = 0;
    logic send_vld = 0; logic [17:0] send_word = 0;
    logic recv_vld = 0; logic [2:0] recv_bkt = 0;
    logic cfg_wr = 0, cfg_sel = 0; logic [6:0] cfg_idx = 0; logic [7:0] cfg_wdata = 0;
    logic [7:0] cfg_rdata; logic [31:0] status;
    logic [1:0] rx_slot = 0; logic [63:0] rx_word;
    logic ring_out_vld; logic [6:0] ring_out_dst, ring_out_src;
    logic [7:0] ring_out_code; logic [1:0] ring_out_szm1; logic [255:0] ring_out_data;
    logic cr_out_vld; logic [6:0] cr_out_stn;

    msg_station #(.CORE_ID(CORE), .BKT_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .txw_en(txw_en), .txw_slot(txw_slot), .txw_data(txw_data),
        .send_vld(send_vld), .send_word(send_word),
        .recv_vld(recv_vld), .recv_bkt(recv_bkt),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .status(status), .rx_slot(rx_slot), .rx_word(rx_word),
        .ring_out_vld(ring_out_vld), .ring_out_dst(ring_out_dst), .ring_out_src(ring_out_src),
        .ring_out_code(ring_out_code), .ring_out_szm1(ring_out_szm1), .ring_out_data(ring_out_data),
        .ring_in_vld(ring_out_vld), .ring_in_dst(ring_out_dst), .ring_in_src(ring_out_src),
        .ring_in_code(ring_out_code), .ring_in_szm1(ring_out_szm1), .ring_in_data(ring_out_data),
        .cr_out_vld(cr_out_vld), .cr_out_stn(cr_out_stn),
        .cr_in_vld(cr_out_vld), .cr_in_stn(cr_out_stn)
    );

    always #4 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    int mcred [128];
    int msize [8];
    bmsg_t mq [8][$];
    bit mfail, mdrop, mbusy, mpend;
    logic [6:0] msrc; logic [7:0] mcode; logic [1:0] mszm1;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        return {9'b0, msrc, mcode, mszm1, mbusy, mdrop, mpend, mfail, 1'b0, 1'b0};
    endfunction

    function automatic int cap(int b);
        return (msize[b] < DEPTH) ? msize[b] : DEPTH;
    endfunction

    task automatic cfg_write(bit sel, int idx, int val);
        @(negedge clk);
        cfg_wr = 1; cfg_sel = sel; cfg_idx = 7'(idx); cfg_wdata = 8'(val);
        @(negedge clk);
        cfg_wr = 0;
        if (sel) msize[idx & 7] = val; else mcred[idx] = val;
    endtask

    task automatic cfg_check(bit sel, int idx, int exp, string tag);
        cfg_sel = sel; cfg_idx = 7'(idx);
        #0.2;
        chk(tag, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic do_send(int dst, logic [7:0] code, logic [1:0] szm1, logic [3:0][63:0] d);
        bit ok;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            txw_en = 1; txw_slot = 2'(s); txw_data = d[s];
        end
        @(negedge clk);
        txw_en = 0; send_vld = 1; send_word = {szm1, code, 1'b0, 7'(dst)};
        @(negedge clk);
        send_vld = 0;
        ok = (mcred[dst] != 0);
        chk("R2 ring_out_vld", 64'(ring_out_vld), 64'(ok));
        chk("R4 in-flight bit", 64'(status[1]), 64'(ok));
        if (ok) begin
            mfail = 0;
            mcred[dst]--;
            chk("R1 dst", 64'(ring_out_dst), 64'(dst));
            chk("R1 src", 64'(ring_out_src), 64'(CORE * 8));
            chk("R1 code", 64'(ring_out_code), 64'(code));
            chk("R1 szm1", 64'(ring_out_szm1), 64'(szm1));
            for (int s = 0; s < 4; s++)
                chk("R1 data", ring_out_data[s*64 +: 64], d[s]);
        end else begin
            mfail = 1;
        end
        chk("R2 fail bit", 64'(status[2]), 64'(mfail));
        @(negedge clk);
        chk("R4 in-flight clears", 64'(status[1]), 64'(0));
        if (ok && (dst >> 3) == CORE) begin
            if (mq[dst & 7].size() < cap(dst & 7))
                mq[dst & 7].push_back('{src: 7'(CORE * 8), code: code, szm1: szm1, d: d});
            else
                mdrop = 1;
        end
        chk("R9 drop bit", 64'(status[4]), 64'(mdrop));
        cfg_check(0, dst, mcred[dst], "R3 credit after send");
    endtask

    task automatic recv_issue(int b);
        @(negedge clk);
        recv_vld = 1; recv_bkt = 3'(b);
        @(negedge clk);
        recv_vld = 0;
        if (mpend) mbusy = 1;
        else begin mpend = 1; mdrop = 0; mbusy = 0; end
        chk("R5 R10 status after receive command", 64'(status), 64'(exp_status()));
    endtask

    task automatic recv_complete(int b);
        bmsg_t m;
        int stn;
        @(negedge clk);
        m = mq[b].pop_front();
        mpend = 0; msrc = m.src; mcode = m.code; mszm1 = m.szm1;
        stn = CORE * 8 + b;
        chk("R6 status after pop", 64'(status), 64'(exp_status()));
        chk("R7 credit return valid", 64'(cr_out_vld), 64'(1));
        chk("R7 credit return station", 64'(cr_out_stn), 64'(stn));
        for (int s = 0; s < 4; s++) begin
            rx_slot = 2'(s);
            #0.2;
            chk("R6 rx word", rx_word, m.d[s]);
        end
        @(negedge clk);
        if (mcred[stn] < 255) mcred[stn]++;
        cfg_check(0, stn, mcred[stn], "R7 credit after return");
    endtask

    function automatic logic [3:0][63:0] rnd_words();
        logic [3:0][63:0] w;
        for (int s = 0; s < 4; s++) w[s] = {$urandom, $urandom};
        return w;
    endfunction

    initial begin
        #(8ns * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 128; i++) mcred[i] = 0;
        for (int i = 0; i < 8; i++) msize[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        chk("R11 status reset", 64'(status), 64'(0));
        chk("R11 ring idle", 64'(ring_out_vld), 64'(0));
        cfg_check(0, 17, 0, "R11 credit reset");
        cfg_check(1, 3, 0, "R11 bucket size reset");

        msize = '{1, 2, 1, 4, 3, 4, 2, 4};
        for (int b = 0; b < 8; b++) cfg_write(1, b, msize[b]);
        cfg_check(1, 2, 1, "R12 bucket size readback");
        cfg_check(1, 7, 4, "R12 bucket size readback");

        // R2: no credit, then credit restores success
        do_send(18, 8'h11, 2'd0, rnd_words());
        cfg_write(0, 18, 2);
        cfg_check(0, 18, 2, "R12 credit readback");
        do_send(18, 8'h22, 2'd1, rnd_words());
        // R9: bucket 2 holds one message, next is dropped
        do_send(18, 8'h33, 2'd2, rnd_words());
        recv_issue(2);
        recv_complete(2);

        // R8: arrival order preserved
        cfg_write(0, 19, 3);
        do_send(19, 8'hA1, 2'd3, rnd_words());
        do_send(19, 8'hB2, 2'd0, rnd_words());
        recv_issue(3); recv_complete(3);
        recv_issue(3); recv_complete(3);

        // R5: receive on empty bucket waits; R10: second command is busy
        recv_issue(0);
        repeat (3) begin
            @(negedge clk);
            chk("R5 pending holds", 64'(status[3]), 64'(1));
        end
        recv_issue(0);
        // R8: other-core message ignored
        cfg_write(0, 40, 1);
        do_send(40, 8'h44, 2'd1, rnd_words());
        repeat (2) begin
            @(negedge clk);
            chk("R8 other core ignored", 64'(status[3]), 64'(1));
        end
        cfg_write(0, 16, 1);
        do_send(16, 8'h55, 2'd2, rnd_words());
        recv_complete(0);

        // R7: saturation at 255
        cfg_write(0, 21, 1);
        do_send(21, 8'h66, 2'd3, rnd_words());
        cfg_write(0, 21, 255);
        recv_issue(5);
        recv_complete(5);

        // random mix
        for (int it = 0; it < 160; it++) begin
            int b, dst;
            b = int'($urandom % 8);
            if ($urandom % 4 == 0) cfg_write(0, CORE * 8 + b, int'($urandom % 3));
            if (($urandom % 2 == 1) && mq[b].size() > 0) begin
                recv_issue(b);
                recv_complete(b);
            end else begin
                dst = ($urandom % 8 == 0) ? int'($urandom % 128) : CORE * 8 + b;
                do_send(dst, 8'($urandom), 2'($urandom), rnd_words());
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule